// File: doc/BRIEF.md
# Programmable-Length Serial Delay Line

This block is a serial shift register whose effective depth can be set to any value from 1 up to a parameter maximum (64 by default). A binary length code selects the depth. A source select picks one of two serial inputs for the first stage. Tying the second input to the block output makes the stored pattern circulate. The block drives a true serial output and its complement, and an asynchronous master reset clears every stage.

Shifting is driven by a slow shift clock and an active-low clock enable. Both are treated as ordinary data signals inside one system-clock domain. Each is registered and compared with its previous sample. A shift happens on a rising shift clock while the enable is low. A shift also happens on a falling enable while the shift clock is high, which gives a falling-edge trigger when the shift clock is held high. Typical uses are a variable digital delay and an odd-length shift register.

Top module: `pdl_delay_line`

## Requirements
- R1: With length code k (0..63), a bit shifted in appears at `dout` after exactly k+1 shifts. The output is stage k, where stage 0 holds the most recent bit.
- R2: `src_sel` = 0 feeds `din_a` into stage 0 on a shift. `src_sel` = 1 feeds `din_b`.
- R3: With `src_sel` = 1 and `din_b` driven from `dout`, the stored pattern of length k+1 circulates unchanged.
- R4: A rising `shift_clk` sample while the sampled `shift_en_n` is 0 causes one shift. While `shift_en_n` is 1, toggling `shift_clk` does not shift.
- R5: A falling `shift_en_n` sample while the sampled `shift_clk` is 1 causes one shift.
- R6: When both trigger conditions occur in the same sample, exactly one shift takes place. Two shifts never occur in consecutive system-clock cycles.
- R7: An input edge that is present before system-clock edge n is stored at edge n+1. The serial data is taken as it stands just before edge n+1.
- R8: `dout_n` is always the complement of `dout`.
- R9: While `rst_n` is low, all stages are 0 at once, so `dout` = 0 and `dout_n` = 1, independent of the clock. After release, no shift occurs until a real edge has been sampled twice. This holds even when `shift_clk` is already high at release.
- R10: A change of `len_code` moves the output to the new tap in the same cycle and leaves the stored data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_clk | input | 1 | Shift clock, sampled |
| shift_en_n | input | 1 | Active-low clock enable, also a falling-edge trigger |
| src_sel | input | 1 | Serial source: 0 = din_a, 1 = din_b |
| din_a | input | 1 | Serial input A |
| din_b | input | 1 | Serial input B |
| len_code | input | 6 | Length minus one |
| dout | output | 1 | True serial output |
| dout_n | output | 1 | Complemented serial output |

## Verification
A trigger edge on `shift_clk` or `shift_en_n` is registered at one system-clock edge. It is compared with the prior sample, and the shift lands on the following edge. The serial data is therefore taken two edges after the control change, and `dout` settles just after that second edge. A change on `len_code` reaches `dout` combinationally in the same cycle, and an asserted `rst_n` clears the outputs at once. The bench drives inputs on falling clock edges and checks each output just before the next input change. The reference model keeps the same two-edge sample history and a bit queue indexed by the length code. Code sweeps and the asynchronous reset are each checked one nanosecond after the change.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Registered view of the two shift control inputs.
  typedef struct packed {
    logic sclk;
    logic en_n;
  } ctl_sample_t;

  // Rising shift clock while enabled.
  function automatic logic rise_trigger(input ctl_sample_t cur, input ctl_sample_t prev);
    return cur.sclk & ~prev.sclk & ~cur.en_n;
  endfunction

  // Enable falling while shift clock is high.
  function automatic logic fall_trigger(input ctl_sample_t cur, input ctl_sample_t prev);
    return ~cur.en_n & prev.en_n & cur.sclk;
  endfunction

  // Length code k selects stage k (length k+1).
  function automatic int unsigned tap_index(input int unsigned code);
    return code;
  endfunction

endpackage

// File: rtl/dl_shift_trigger.sv
module dl_shift_trigger
  import dl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_clk,
  input  logic shift_en_n,
  output logic shift_pulse
);

  ctl_sample_t cur_q, prev_q;
  logic        arm0_q, armed_q;
  logic        rise_evt, fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      prev_q  <= '0;
      arm0_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cur_q.sclk <= shift_clk;
      cur_q.en_n <= shift_en_n;
      prev_q     <= cur_q;
      arm0_q     <= 1'b1;
      armed_q    <= arm0_q;
    end
  end

  assign rise_evt    = armed_q & rise_trigger(cur_q, prev_q);
  assign fall_evt    = armed_q & fall_trigger(cur_q, prev_q);
  assign shift_pulse = rise_evt | fall_evt;

  // R6: trigger conditions cannot recur on the next cycle
  p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> !shift_pulse);

  // R9: first sample after reset release never triggers
  p_quiet_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm0_q) |-> !shift_pulse);

endmodule

// File: rtl/dl_stage_chain.sv
module dl_stage_chain #(
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stages <= '0;
    else if (shift) stages <= {stages[DEPTH-2:0], din};
  end

  // R2: selected serial bit lands in stage 0
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> stages[0] == $past(din));

  // R1: every stage advances by one
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0]));

  // R4: no trigger, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(stages));

endmodule

// File: rtl/dl_tap_select.sv
module dl_tap_select
  import dl_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LEN_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] stages,
  input  logic [LEN_W-1:0] len_code,
  output logic             tap
);

  always_comb begin
    tap = 1'b0;
    for (int unsigned i = 0; i < DEPTH; i++) begin
      if (tap_index(32'(len_code)) == i) tap = stages[i];
    end
  end

endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line #(
  parameter int unsigned MAX_STAGES = 64,
  localparam int unsigned LEN_W = $clog2(MAX_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_clk,
  input  logic             shift_en_n,
  input  logic             src_sel,
  input  logic             din_a,
  input  logic             din_b,
  input  logic [LEN_W-1:0] len_code,
  output logic             dout,
  output logic             dout_n
);

  logic                  shift_pulse;
  logic                  serial_in;
  logic [MAX_STAGES-1:0] stages;
  logic                  tap;

  assign serial_in = src_sel ? din_b : din_a;

  dl_shift_trigger u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_clk  (shift_clk),
    .shift_en_n (shift_en_n),
    .shift_pulse(shift_pulse)
  );

  dl_stage_chain #(.DEPTH(MAX_STAGES)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (shift_pulse),
    .din   (serial_in),
    .stages(stages)
  );

  dl_tap_select #(.DEPTH(MAX_STAGES)) u_tap (
    .stages  (stages),
    .len_code(len_code),
    .tap     (tap)
  );

  assign dout   = tap;
  assign dout_n = ~tap;

  // R10: without a shift or a code change the output holds
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_pulse && $stable(len_code)) |=> ($stable(dout) || !$stable(len_code)));

  // R3: in recirculation the output feeds stage 0 on a shift
  p_recirc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_pulse && src_sel && (din_b == dout)) |=> stages[0] == $past(dout));

endmodule

// File: tb/tb_pdl_delay_line.sv
module tb_pdl_delay_line;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       shift_clk, shift_en_n, src_sel, din_a, din_b;
  logic [5:0] len_code;
  logic       dout, dout_n;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  pdl_delay_line dut (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .shift_en_n(shift_en_n),
    .src_sel(src_sel), .din_a(din_a), .din_b(din_b), .len_code(len_code),
    .dout(dout), .dout_n(dout_n)
  );

  // Reference model: bit queue, newest first, plus sample history.
  bit q[$];
  int cnt;
  bit s1, s2, c1, c2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cnt = 0; s1 = 0; s2 = 0; c1 = 0; c2 = 0;
    end else begin
      if (cnt < 3) cnt++;
      if (cnt >= 3 && ((s1 && !s2 && !c1) || (!c1 && c2 && s1))) begin
        q.push_front(src_sel ? din_b : din_a);
        if (q.size() > 64) void'(q.pop_back());
      end
      s2 = s1; c2 = c1;
      s1 = shift_clk; c1 = shift_en_n;
    end
  end

  function automatic bit exp_out();
    if (int'(len_code) < q.size()) return q[len_code];
    return 1'b0;
  endfunction

  function automatic bit rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic check(string tag);
    bit e;
    e = exp_out();
    nchk++;
    if (dout !== e) begin
      nfail++;
      $display("FAIL %s: dout=%b expected %b at %0t", tag, dout, e, $time);
    end
    nchk++;
    if (dout_n !== !e) begin
      nfail++;
      $display("FAIL R8: dout_n=%b expected %b at %0t", dout_n, !e, $time);
    end
  endtask

  task automatic cyc(string tag, bit s, bit c, bit sl, bit av, bit bv, bit recirc = 0);
    @(negedge clk);
    check(tag);
    shift_clk  = s;
    shift_en_n = c;
    src_sel    = sl;
    din_a      = av;
    din_b      = recirc ? dout : bv;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; shift_clk = 1; shift_en_n = 0; src_sel = 0;
    din_a = 1; din_b = 0; len_code = 0;
    #7 check("R9");
    @(negedge clk) rst_n = 1;
    // R9: shift_clk already high at release must not shift
    repeat (6) cyc("R9", 1, 0, 0, 1, 0);
    // R4 / R7: rising shift clock with enable low
    len_code = 2;
    for (int i = 0; i < 24; i++) cyc("R4", i[0], 0, 0, rnd(), 0);
    // R4: enable high blocks shifting
    for (int i = 0; i < 16; i++) cyc("R4", i[0], 1, 0, rnd(), 0);
    // R5: falling enable with shift clock high
    for (int i = 0; i < 20; i++) cyc("R5", 1, i[0], 0, rnd(), 0);
    // R6: both triggers in one sample
    len_code = 0;
    for (int i = 0; i < 10; i++) begin
      cyc("R6", 0, 1, 0, rnd(), 0);
      cyc("R6", 1, 0, 0, rnd(), 0);
      cyc("R6", 1, 0, 0, 0, 0);
    end
    // R2: source B selected, A carries the opposite value
    len_code = 3;
    for (int i = 0; i < 24; i++) begin
      bit v;
      v = rnd();
      cyc("R2", i[0], 0, 1, !v, v);
    end
    // R7: two-edge latency at length 1
    len_code = 0;
    for (int i = 0; i < 16; i++) cyc("R7", i[1], 0, 0, rnd(), 0);
    // R3: load five bits, then circulate
    len_code = 4;
    for (int i = 0; i < 12; i++) cyc("R3", i[0], 0, 0, rnd(), 0);
    for (int i = 0; i < 60; i++) cyc("R3", i[0], 0, 1, 0, 0, 1);
    // R10: sweep length codes with shifting stopped
    cyc("R10", 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0);
    for (int k = 0; k < 64; k += 3) begin
      @(negedge clk);
      len_code = 6'(k);
      #1 check("R10");
    end
    // R1: long run at full length, then mixed lengths
    len_code = 63;
    for (int i = 0; i < 160; i++) cyc("R1", i[0], 0, 0, rnd(), 0);
    for (int i = 0; i < 400; i++) begin
      if (i % 40 == 0) len_code = {rnd(), rnd(), rnd(), rnd(), rnd(), rnd()};
      cyc("R1", i[0], rnd() & rnd(), rnd(), rnd(), rnd());
    end
    // R9: asynchronous reset in mid-cycle
    @(negedge clk);
    #1 rst_n = 0;
    #1 check("R9");
    @(negedge clk);
    shift_clk = 1; shift_en_n = 0; din_a = 1; len_code = 0;
    rst_n = 1;
    repeat (5) cyc("R9", 1, 0, 0, 1, 0);
    for (int i = 0; i < 12; i++) cyc("R1", i[0], 0, 0, rnd(), 0);
    finish_run();
  end

endmodule